// File: doc/BRIEF.md
# Amplifier Control Serial Register Slave

This block is the serial-bus slave of an audio amplifier controller. It samples the two lines of an I2C-compatible bus with the system clock, finds START and STOP conditions, and answers one 7-bit device address. The top five address bits are fixed at elaboration and the two low bits come from strap pins. After the address, the master writes an index byte that points into a bank of eight byte-wide registers. Further bytes in a write go to the register the index points at. A read returns bytes from that register. Bit 7 of the index byte chooses whether the pointer steps forward after each data byte.

The bank holds amplifier settings: mute, sleep, input-limit code, the configuration word and two per-channel volume words. These drive plain output pins. The bank also reflects status, fault, speaker-presence and volume-converter inputs supplied by neighbouring logic. Two status flags are sticky: they capture overload and current-limit events and stay set until the master writes 0 to them. The block has no pad drivers. It drives an open-drain enable that pulls SDA low when high, and it never stretches the clock.

Top module: `amp_i2c_regs`

## Requirements
- R1: After reset, CONTROL and CONFIGURATION outputs are all 0, both volume words are 8'hFF, the index pointer is 0 and SDA is released (`sda_oe` = 0).
- R2: A START (SDA falling while SCL is high) begins a transfer, including a repeated START in mid-transfer. A STOP (SDA rising while SCL is high) ends it and releases SDA.
- R3: The slave acknowledges an address byte only when its upper seven bits equal {5'b10000, addr_strap}, with the LSB as R/W (0 = write, 1 = read). On a mismatch it stays silent and ignores the rest of the transfer.
- R4: The slave changes its SDA drive only while SCL is low. Bytes are sent MSB first.
- R5: The first data byte of a write loads the index. Bits 6:0 select the register. If bit 7 is 1, bits 6:0 advance by one (wrapping 127 to 0) after every data byte written or read. If bit 7 is 0, the index stays fixed.
- R6: STATUS (index 0) reads {overload, current-limit, 3'b000, silence, muted, fault}. Bits 7 and 6 are sticky. They set on `ev_overload` and `ev_overcurrent`, clear only when a write puts 0 in that bit, and are unchanged by writing 1. If an event and a clear occur together, the set wins. Bits 2:0 follow their inputs.
- R7: FAULT (index 1) reads {4'b0000, flt_bits}. INITIAL STATE (index 2) reads {2'b00, spk_missing[1], spk_missing[0], 4'b0000}. VOLUME ADC (index 3) reads `vol_adc`. Writes to these three registers have no effect.
- R8: CONTROL (index 4) holds mute in bit 7, sleep in bit 6 and the input-limit code in bits 2:0. These drive `ctl_mute`, `ctl_sleep` and `ctl_limit`. Bits 5:3 read 0 and ignore writes.
- R9: CONFIGURATION (index 5) stores bits 6:0, which read back and drive `cfg_bits`. Bit 7 reads 0.
- R10: VOLUME1 (index 6) and VOLUME2 (index 7) are full 8-bit read/write registers that drive `vol_ch1` and `vol_ch2`. They change only on a write addressed to them.
- R11: Indices 8 to 127 read as 0, and writes to them change no register.
- R12: A read starts at the current index (0 if none was written since reset). After a master ACK the next byte follows. After a master NACK the slave releases SDA before the STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| addr_strap | input | 2 | Two low bits of the device address |
| ev_overload | input | 1 | Input overload event, sets the sticky STATUS bit 7 |
| ev_overcurrent | input | 1 | Current-limit event, sets the sticky STATUS bit 6 |
| st_silence | input | 1 | Silence-mute state, STATUS bit 2 |
| st_muted | input | 1 | Outputs-muted state, STATUS bit 1 |
| st_fault | input | 1 | Fault summary, STATUS bit 0 |
| flt_bits | input | 4 | Fault causes: 3 current shutdown, 2 supply mute, 1 over-temperature, 0 voltage |
| spk_missing | input | 2 | Missing-speaker flags, bit 1 channel 2, bit 0 channel 1 |
| vol_adc | input | 8 | Digitised analog volume setting |
| ctl_mute | output | 1 | Mute request |
| ctl_sleep | output | 1 | Sleep request |
| ctl_limit | output | 3 | Input-limit level code |
| cfg_bits | output | 7 | Configuration word: zero-cross, ramp, volume source, silence time[1:0], silence level[1:0] |
| vol_ch1 | output | 8 | Channel 1 volume word |
| vol_ch2 | output | 8 | Channel 2 volume word |

## Verification
The hardest state to reach from the pins is the sticky flag at the moment of a clear. An event must be captured, then removed, and then a write must land with a 0 in exactly one of the two flag bits while the other is 1. The bench pulses each event input between bus transactions, then reads STATUS back after writes of all ones, a 0 in bit 7 only, and a 0 in bit 6 only. The bench also reaches index wrap-around by loading index 127 with auto-increment and reading two bytes. It sweeps all 128 address bytes to show that only the strapped address is acknowledged.

// File: rtl/amp_i2c_pkg.sv
package amp_i2c_pkg;

  typedef enum logic [2:0] {
    BS_IDLE,
    BS_RX,
    BS_ACK,
    BS_TX,
    BS_MACK
  } bus_state_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_INDEX,
    PH_DATA
  } rx_phase_e;

  localparam int IDX_W = 7;
  localparam int NUM_CH = 2;

  localparam logic [IDX_W-1:0] RI_STATUS = 7'd0;
  localparam logic [IDX_W-1:0] RI_FAULT  = 7'd1;
  localparam logic [IDX_W-1:0] RI_INIT   = 7'd2;
  localparam logic [IDX_W-1:0] RI_VADC   = 7'd3;
  localparam logic [IDX_W-1:0] RI_CTRL   = 7'd4;
  localparam logic [IDX_W-1:0] RI_CFG    = 7'd5;
  localparam logic [IDX_W-1:0] RI_VOL1   = 7'd6;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] synced;
  logic scl_q, sda_q;

  assign raw = {scl_i, sda_i};

  genvar g;
  generate
    for (g = 0; g < NLINES; g++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], raw[g]};
      end
      assign synced[g] = chain[STAGES-1];
    end
  endgenerate

  assign scl_s = synced[1];
  assign sda_s = synced[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  =  scl_s & ~scl_q;
  assign scl_fall  = ~scl_s &  scl_q;
  assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
  assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;

endmodule

// File: rtl/i2c_slave_engine.sv
module i2c_slave_engine
  import amp_i2c_pkg::*;
#(
  parameter logic [4:0] DEV_ADDR_HI = 5'b10000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [1:0]       addr_strap,
  input  logic [7:0]       rd_data,
  output logic [IDX_W-1:0] rd_idx,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_addr,
  output logic [7:0]       wr_data,
  output logic             sda_oe
);
  localparam int BITS = 8;
  localparam logic [3:0] LAST_BIT = 4'(BITS - 1);

  bus_state_e state;
  rx_phase_e  phase;
  logic [7:0] sh;
  logic [3:0] cnt;
  logic [7:0] idx;
  logic       rw;
  logic       mack;

  assign rd_idx = idx[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= BS_IDLE;
      phase   <= PH_ADDR;
      sh      <= '0;
      cnt     <= '0;
      idx     <= '0;
      rw      <= 1'b0;
      mack    <= 1'b0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (stop_det) begin
        state  <= BS_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        state  <= BS_RX;
        phase  <= PH_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          BS_RX: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'(BITS)) begin
              cnt <= '0;
              case (phase)
                PH_ADDR: begin
                  if (sh[7:1] == {DEV_ADDR_HI, addr_strap}) begin
                    rw     <= sh[0];
                    sda_oe <= 1'b1;
                    state  <= BS_ACK;
                  end else begin
                    state  <= BS_IDLE;
                  end
                end
                PH_INDEX: begin
                  idx    <= sh;
                  phase  <= PH_DATA;
                  sda_oe <= 1'b1;
                  state  <= BS_ACK;
                end
                default: begin
                  wr_en   <= 1'b1;
                  wr_addr <= idx[IDX_W-1:0];
                  wr_data <= sh;
                  if (idx[7]) idx[IDX_W-1:0] <= idx[IDX_W-1:0] + 7'd1;
                  sda_oe  <= 1'b1;
                  state   <= BS_ACK;
                end
              endcase
            end
          end
          BS_ACK: begin
            if (scl_fall) begin
              if (phase == PH_ADDR && rw) begin
                sh     <= rd_data;
                sda_oe <= ~rd_data[7];
                cnt    <= '0;
                if (idx[7]) idx[IDX_W-1:0] <= idx[IDX_W-1:0] + 7'd1;
                state  <= BS_TX;
              end else begin
                sda_oe <= 1'b0;
                if (phase == PH_ADDR) phase <= PH_INDEX;
                state  <= BS_RX;
              end
            end
          end
          BS_TX: begin
            if (scl_fall) begin
              if (cnt == LAST_BIT) begin
                sda_oe <= 1'b0;
                cnt    <= '0;
                state  <= BS_MACK;
              end else begin
                sh     <= {sh[6:0], 1'b0};
                sda_oe <= ~sh[6];
                cnt    <= cnt + 4'd1;
              end
            end
          end
          BS_MACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                sh     <= rd_data;
                sda_oe <= ~rd_data[7];
                cnt    <= '0;
                if (idx[7]) idx[IDX_W-1:0] <= idx[IDX_W-1:0] + 7'd1;
                state  <= BS_TX;
              end else begin
                state  <= BS_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/amp_reg_bank.sv
module amp_reg_bank
  import amp_i2c_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_addr,
  output logic [7:0]       rd_data,
  input  logic             ev_overload,
  input  logic             ev_overcurrent,
  input  logic             st_silence,
  input  logic             st_muted,
  input  logic             st_fault,
  input  logic [3:0]       flt_bits,
  input  logic [1:0]       spk_missing,
  input  logic [7:0]       vol_adc,
  output logic             ctl_mute,
  output logic             ctl_sleep,
  output logic [2:0]       ctl_limit,
  output logic [6:0]       cfg_bits,
  output logic [7:0]       vol_ch1,
  output logic [7:0]       vol_ch2
);
  logic ovl_q, ocl_q;
  logic stat_wr;
  logic [7:0] vol_q [NUM_CH];

  assign stat_wr = wr_en && (wr_addr == RI_STATUS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovl_q     <= 1'b0;
      ocl_q     <= 1'b0;
      ctl_mute  <= 1'b0;
      ctl_sleep <= 1'b0;
      ctl_limit <= '0;
      cfg_bits  <= '0;
    end else begin
      ovl_q <= ev_overload    | (ovl_q & ~(stat_wr & ~wr_data[7]));
      ocl_q <= ev_overcurrent | (ocl_q & ~(stat_wr & ~wr_data[6]));
      if (wr_en && wr_addr == RI_CTRL) begin
        ctl_mute  <= wr_data[7];
        ctl_sleep <= wr_data[6];
        ctl_limit <= wr_data[2:0];
      end
      if (wr_en && wr_addr == RI_CFG) cfg_bits <= wr_data[6:0];
    end
  end

  genvar ch;
  generate
    for (ch = 0; ch < NUM_CH; ch++) begin : g_vol
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(RI_VOL1 + ch);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             vol_q[ch] <= 8'hFF;
        else if (wr_en && wr_addr == MY_IDX)    vol_q[ch] <= wr_data;
      end
    end
  endgenerate

  assign vol_ch1 = vol_q[0];
  assign vol_ch2 = vol_q[1];

  always_comb begin
    case (rd_addr)
      RI_STATUS: rd_data = {ovl_q, ocl_q, 3'b000, st_silence, st_muted, st_fault};
      RI_FAULT:  rd_data = {4'b0000, flt_bits};
      RI_INIT:   rd_data = {2'b00, spk_missing[1], spk_missing[0], 4'b0000};
      RI_VADC:   rd_data = vol_adc;
      RI_CTRL:   rd_data = {ctl_mute, ctl_sleep, 3'b000, ctl_limit};
      RI_CFG:    rd_data = {1'b0, cfg_bits};
      RI_VOL1:   rd_data = vol_q[0];
      RI_VOL1 + 7'd1: rd_data = vol_q[1];
      default:   rd_data = 8'h00;
    endcase
  end

endmodule

// File: rtl/amp_i2c_regs.sv
module amp_i2c_regs
  import amp_i2c_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] DEV_ADDR_HI = 5'b10000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [1:0] addr_strap,
  input  logic       ev_overload,
  input  logic       ev_overcurrent,
  input  logic       st_silence,
  input  logic       st_muted,
  input  logic       st_fault,
  input  logic [3:0] flt_bits,
  input  logic [1:0] spk_missing,
  input  logic [7:0] vol_adc,
  output logic       ctl_mute,
  output logic       ctl_sleep,
  output logic [2:0] ctl_limit,
  output logic [6:0] cfg_bits,
  output logic [7:0] vol_ch1,
  output logic [7:0] vol_ch2
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [IDX_W-1:0] rd_idx, wr_addr;
  logic [7:0] rd_data, wr_data;
  logic wr_en;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_slave_engine #(.DEV_ADDR_HI(DEV_ADDR_HI)) eng_i (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .addr_strap(addr_strap),
    .rd_data(rd_data), .rd_idx(rd_idx), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sda_oe(sda_oe)
  );

  amp_reg_bank bank_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_idx), .rd_data(rd_data),
    .ev_overload(ev_overload), .ev_overcurrent(ev_overcurrent),
    .st_silence(st_silence), .st_muted(st_muted), .st_fault(st_fault),
    .flt_bits(flt_bits), .spk_missing(spk_missing), .vol_adc(vol_adc),
    .ctl_mute(ctl_mute), .ctl_sleep(ctl_sleep), .ctl_limit(ctl_limit),
    .cfg_bits(cfg_bits), .vol_ch1(vol_ch1), .vol_ch2(vol_ch2)
  );

endmodule

// File: rtl/amp_i2c_regs_chk.sv
module amp_i2c_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_oe,
  input logic       start_det,
  input logic       stop_det,
  input logic       wr_en,
  input logic       ev_overload,
  input logic [6:0] rd_idx,
  input logic [7:0] rd_data,
  input logic       ctl_mute,
  input logic       ctl_sleep,
  input logic [7:0] vol_ch1,
  input logic [7:0] vol_ch2
);

  p_stop_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  p_drive_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(stop_det) && !$past(start_det)) |-> !scl_s);

  p_sticky_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overload |=> (rd_idx != 7'd0 || rd_data[7]));

  p_ctl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(ctl_mute) && $stable(ctl_sleep)));

  p_vol_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(vol_ch1) && $stable(vol_ch2)));

endmodule

bind amp_i2c_regs amp_i2c_regs_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .start_det(start_det), .stop_det(stop_det), .wr_en(wr_en),
  .ev_overload(ev_overload), .rd_idx(rd_idx), .rd_data(rd_data),
  .ctl_mute(ctl_mute), .ctl_sleep(ctl_sleep),
  .vol_ch1(vol_ch1), .vol_ch2(vol_ch2)
);

// File: tb/amp_i2c_regs_tb_top.sv
module amp_i2c_regs_tb_top;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_bus, sda_oe;
  logic [1:0] addr_strap = 2'b10;
  logic ev_overload = 1'b0, ev_overcurrent = 1'b0;
  logic st_silence = 1'b1, st_muted = 1'b0, st_fault = 1'b1;
  logic [3:0] flt_bits = 4'b1010;
  logic [1:0] spk_missing = 2'b01;
  logic [7:0] vol_adc = 8'h5A;
  logic ctl_mute, ctl_sleep;
  logic [2:0] ctl_limit;
  logic [6:0] cfg_bits;
  logic [7:0] vol_ch1, vol_ch2;

  int checks = 0, failures = 0;
  bit done = 0;

  // bench model of writable state
  logic m_ovl = 0, m_ocl = 0;
  logic [7:0] m_ctl = 8'h00, m_cfg = 8'h00, m_v1 = 8'hFF, m_v2 = 8'hFF;

  always #2.5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  amp_i2c_regs dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_strap(addr_strap), .ev_overload(ev_overload),
    .ev_overcurrent(ev_overcurrent), .st_silence(st_silence),
    .st_muted(st_muted), .st_fault(st_fault), .flt_bits(flt_bits),
    .spk_missing(spk_missing), .vol_adc(vol_adc), .ctl_mute(ctl_mute),
    .ctl_sleep(ctl_sleep), .ctl_limit(ctl_limit), .cfg_bits(cfg_bits),
    .vol_ch1(vol_ch1), .vol_ch2(vol_ch2)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_reg(input int i);
    case (i)
      0: return {m_ovl, m_ocl, 3'b000, st_silence, st_muted, st_fault};
      1: return {4'b0000, flt_bits};
      2: return {2'b00, spk_missing, 4'b0000};
      3: return vol_adc;
      4: return m_ctl;
      5: return m_cfg;
      6: return m_v1;
      7: return m_v2;
      default: return 8'h00;
    endcase
  endfunction

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; waitq(); scl = 1'b1; waitq();
    sda_m = 1'b0; waitq(); scl = 1'b0; waitq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; waitq(); scl = 1'b1; waitq(); sda_m = 1'b1; waitq();
  endtask

  task automatic bus_bit(input logic b, output logic s);
    sda_m = b; waitq(); scl = 1'b1; waitq();
    s = sda_bus; scl = 1'b0; waitq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, s);
      b[i] = s;
    end
    bus_bit(~give_ack, s);
  endtask

  function automatic logic [7:0] dev(input logic rd);
    return {5'b10000, addr_strap, rd};
  endfunction

  task automatic reg_wr(input logic [7:0] idx, input logic [7:0] d);
    logic a;
    bus_start(); send_byte(dev(0), a); send_byte(idx, a); send_byte(d, a); bus_stop();
  endtask

  task automatic reg_rd(input logic [7:0] idx, output logic [7:0] d);
    logic a;
    bus_start(); send_byte(dev(0), a); send_byte(idx, a);
    bus_start(); send_byte(dev(1), a); recv_byte(1'b0, d); bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic a;
    logic [7:0] vals [7] = '{8'h00, 8'h01, 8'h55, 8'hAA, 8'h7F, 8'h80, 8'hFE};
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 ctl_mute", ctl_mute, 0);
    chk("R1 ctl_sleep", ctl_sleep, 0);
    chk("R1 ctl_limit", ctl_limit, 0);
    chk("R1 cfg_bits", cfg_bits, 0);
    chk("R1 vol_ch1", vol_ch1, 8'hFF);
    chk("R1 vol_ch2", vol_ch2, 8'hFF);
    chk("R1 sda_oe", sda_oe, 0);

    // R12 read with no index written starts at index 0 (R1)
    bus_start(); send_byte(dev(1), a);
    chk("R3 read address ack", a, 1);
    recv_byte(1'b0, d);
    chk("R12 R1 read from reset index", d, exp_reg(0));
    bus_stop();

    // R3 address sweep
    for (int ad = 0; ad < 128; ad++) begin
      bus_start(); send_byte({ad[6:0], 1'b0}, a); bus_stop();
      chk($sformatf("R3 ack for addr %0h", ad), a, (ad[6:0] == {5'b10000, addr_strap}));
    end

    // R5 R6 R7 auto-increment read of whole map
    bus_start(); send_byte(dev(0), a); send_byte(8'h80, a);
    bus_start(); send_byte(dev(1), a);
    for (int i = 0; i < 8; i++) begin
      recv_byte(i != 7, d);
      chk($sformatf("R5 R7 autoinc read idx %0d", i), d, exp_reg(i));
    end
    chk("R12 SDA released after NACK", sda_oe, 0);
    bus_stop();

    // R8 control
    reg_wr(8'h04, 8'hFF); m_ctl = 8'hC7;
    reg_rd(8'h04, d);
    chk("R8 control readback", d, 8'hC7);
    chk("R8 ctl pins", {ctl_mute, ctl_sleep, ctl_limit}, 5'b11111);
    reg_wr(8'h04, 8'h45); m_ctl = 8'h45;
    chk("R8 ctl pins second", {ctl_mute, ctl_sleep, ctl_limit}, 5'b01101);

    // R9 configuration
    reg_wr(8'h05, 8'hFF); m_cfg = 8'h7F;
    reg_rd(8'h05, d);
    chk("R9 config readback", d, 8'h7F);
    chk("R9 cfg pins", cfg_bits, 7'h7F);
    reg_wr(8'h05, 8'h2A); m_cfg = 8'h2A;
    chk("R9 cfg pins second", cfg_bits, 7'h2A);

    // R7 read-only registers ignore writes
    for (int i = 1; i <= 3; i++) begin
      reg_wr(i[7:0], 8'hFF);
      reg_rd(i[7:0], d);
      chk($sformatf("R7 read-only idx %0d", i), d, exp_reg(i));
    end

    // R10 volume sweep
    for (int k = 0; k < 7; k++) begin
      reg_wr(8'h06, vals[k]); m_v1 = vals[k];
      reg_wr(8'h07, ~vals[k]); m_v2 = ~vals[k];
      reg_rd(8'h06, d);
      chk("R10 vol1 readback", d, m_v1);
      reg_rd(8'h07, d);
      chk("R10 vol2 readback", d, m_v2);
      chk("R10 vol pins", {vol_ch1, vol_ch2}, {m_v1, m_v2});
    end

    // R5 auto-increment write
    bus_start(); send_byte(dev(0), a); send_byte(8'h86, a);
    send_byte(8'h11, a); send_byte(8'h22, a); bus_stop();
    m_v1 = 8'h11; m_v2 = 8'h22;
    chk("R5 autoinc write", {vol_ch1, vol_ch2}, 16'h1122);
    // R5 fixed index write
    bus_start(); send_byte(dev(0), a); send_byte(8'h06, a);
    send_byte(8'h33, a); send_byte(8'h44, a); bus_stop();
    m_v1 = 8'h44;
    chk("R5 fixed index write", {vol_ch1, vol_ch2}, 16'h4422);

    // R5 wrap 127 -> 0
    bus_start(); send_byte(dev(0), a); send_byte(8'hFF, a);
    bus_start(); send_byte(dev(1), a);
    recv_byte(1'b1, d);
    chk("R5 R11 idx 127 reads 0", d, 8'h00);
    recv_byte(1'b0, d);
    chk("R5 wrap to STATUS", d, exp_reg(0));
    bus_stop();

    // R11 out-of-range index
    reg_wr(8'h10, 8'hAB);
    reg_wr(8'h08, 8'hCD);
    reg_rd(8'h10, d);
    chk("R11 idx 16 reads 0", d, 8'h00);
    reg_rd(8'h08, d);
    chk("R11 idx 8 reads 0", d, 8'h00);
    chk("R11 nothing changed", {vol_ch1, vol_ch2, 1'b0, cfg_bits, ctl_mute, ctl_sleep, ctl_limit},
        {m_v1, m_v2, m_cfg, m_ctl[7:6], m_ctl[2:0]});

    // R6 sticky flags
    ev_overload = 1'b1; repeat (3) @(negedge clk); ev_overload = 1'b0; m_ovl = 1;
    ev_overcurrent = 1'b1; repeat (3) @(negedge clk); ev_overcurrent = 1'b0; m_ocl = 1;
    reg_rd(8'h00, d);
    chk("R6 both flags set", d, exp_reg(0));
    reg_wr(8'h00, 8'hFF);
    reg_rd(8'h00, d);
    chk("R6 writing ones keeps flags", d, exp_reg(0));
    reg_wr(8'h00, 8'h7F); m_ovl = 0;
    reg_rd(8'h00, d);
    chk("R6 clear bit7 only", d, exp_reg(0));
    reg_wr(8'h00, 8'h80); m_ocl = 0;
    reg_rd(8'h00, d);
    chk("R6 clear bit6 only", d, exp_reg(0));
    st_silence = 1'b0; st_muted = 1'b1; st_fault = 1'b0;
    reg_rd(8'h00, d);
    chk("R6 live status bits", d, 8'h02);

    // R3 wrong address: bytes ignored
    bus_start(); send_byte({7'h21, 1'b0}, a);
    chk("R3 wrong addr nack", a, 0);
    send_byte(8'h06, a); send_byte(8'h99, a);
    chk("R3 no ack after mismatch", a, 0);
    bus_stop();
    chk("R3 mismatch no write", vol_ch1, m_v1);

    // R3 R2 new strap value, read via repeated start
    addr_strap = 2'b01;
    repeat (4) @(negedge clk);
    reg_rd(8'h07, d);
    chk("R3 R2 strap 01 read", d, m_v2);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule